// File: doc/BRIEF.md
# Interrupt Acknowledge and Report Sequencer

This block watches seven backplane interrupt request lines and an incoming stream of status/ID words. When an enabled request line is active, it runs interrupt-acknowledge cycles one after another, highest line first. It keeps going until no enabled line is still asserted. Each acknowledge cycle returns a status/ID word, and that word is stored with the number of the line it came from. Words offered on the signal input are gathered into the same buffer. Once the burst is over, the whole set goes out to the host as a single report.

After a report has been fully transferred, a one-shot gate closes. No acknowledge cycle runs, no signal word is accepted and no new report is made until the host pulses its okay-to-send input. Requests that arrive while the gate is closed stay pending and are serviced after the re-arm, so nothing is lost. An acknowledge cycle that gets no answer ends after a programmable number of cycles and is recorded as a bus error.

The report buffer holds 16 entries. If it fills while sources are still waiting, a sticky overflow flag is set and the burst ends early. The waiting sources are left untouched.

Streams use valid/ready. A word transfers on a clock edge where both valid and ready are high. The sequencer holds `rpt_data` and `rpt_last` stable while `rpt_valid` is high and `rpt_ready` is low. The signal source must hold `sig_id` stable while `sig_valid` is high and `sig_ready` is low. The sequencer may hold `sig_ready` low for any number of cycles.

Top module: `irq_report_seq`

## Requirements
- R1: After reset, `iack_req`, `rpt_valid`, `rpt_event` and `ovf_flag` are low, and the gate is open: with no line pending and the buffer empty, `sig_ready` is high.
- R2: Line k (1..7) is bit k-1 of `irq_lines` and of `irq_en`. Only lines that are asserted and enabled start acknowledge cycles. A pending line whose enable bit is low is never acknowledged and never appears in a report.
- R3: When several eligible lines are pending, the highest-numbered one is acknowledged first. During an acknowledge cycle, `iack_level` carries the line number 1..7 in binary.
- R4: `iack_req` stays high with a constant `iack_level` until `iack_ack` is seen high, or until the timeout expires. A one-cycle `iack_ack` delivers `iack_id`, which is stored as that entry's ID.
- R5: If `iack_ack` does not arrive within `to_limit`+1 cycles of `iack_req`, the entry is stored with the error bit set and an ID of zero. That line is then skipped for the rest of the burst.
- R6: Acknowledge cycles repeat until no enabled, non-skipped line is asserted. Eligible interrupt lines take precedence over signal words. A signal word is accepted only while no eligible line is pending, and it is stored with source code 0.
- R7: When a non-empty burst ends, `rpt_event` pulses high for exactly one cycle. The entries then stream out in the order they were collected, with `rpt_last` high on the final one, and are held stable under back-pressure.
- R8: Once the last report word has transferred, no acknowledge cycle, no signal-word accept and no report happens until `host_ok` is seen high.
- R9: Lines and signal words that become pending while the gate is closed are serviced in the first burst after `host_ok`.
- R10: The buffer holds 16 entries. Filling it exactly, with nothing else pending, is not an overflow. If a further source is pending while the buffer is full, `ovf_flag` is set, the burst ends and that source stays pending. `ovf_flag` stays high until `host_ok` re-arms the sequencer.
- R11: Each report word is laid out as `rpt_data[19:17]` = source (line number, or 0 for a signal word), `rpt_data[16]` = bus-error bit, and `rpt_data[15:0]` = status/ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 7 | Interrupt request lines; bit k-1 is line k |
| irq_en | input | 7 | Host enable mask, same bit order |
| iack_req | output | 1 | Acknowledge cycle in progress |
| iack_level | output | 3 | Line number being acknowledged |
| iack_ack | input | 1 | Acknowledge answer, one cycle |
| iack_id | input | 16 | Status/ID returned with `iack_ack` |
| to_limit | input | 8 | Acknowledge timeout; the window is `to_limit`+1 cycles |
| sig_valid | input | 1 | Signal word offered |
| sig_ready | output | 1 | Signal word accepted this cycle |
| sig_id | input | 16 | Signal status/ID word |
| rpt_valid | output | 1 | Report word valid |
| rpt_ready | input | 1 | Host accepts report word |
| rpt_data | output | 20 | Report word (source, error bit, ID) |
| rpt_last | output | 1 | Final word of the report |
| rpt_event | output | 1 | One-cycle report-ready pulse |
| host_ok | input | 1 | Okay-to-send re-arm |
| ovf_flag | output | 1 | Sticky buffer overflow |

## Verification
The assertions assume the following about the inputs:
- `iack_ack` is raised only while `iack_req` is high and only for one cycle.
- An interrupter releases its line no later than the edge on which its acknowledge is taken.
- The signal source holds its word steady until it is accepted.

The bench's responder model meets all three. It answers only the level currently driven on `iack_level`, clears that line's request in the same cycle as the acknowledge, and drops the acknowledge on the next cycle. The signal queue advances only on an edge where valid and ready are both high. Lines marked as dead never answer, which exercises the timeout path without breaking any of these assumptions.

// File: rtl/irq_report_pkg.sv
package irq_report_pkg;
  localparam int LINES = 7;
  localparam int LVL_W = $clog2(LINES + 1);
  localparam int ID_W  = 16;

  typedef struct packed {
    logic [LVL_W-1:0] src;
    logic             berr;
    logic [ID_W-1:0]  id;
  } rpt_entry_t;

  localparam int ENTRY_W = $bits(rpt_entry_t);

  typedef enum logic [1:0] {
    ST_GATHER = 2'd0,
    ST_IACK   = 2'd1,
    ST_SEND   = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/irq_level_pick.sv
// Picks the highest-numbered active request; output level is index+1.
module irq_level_pick #(
  parameter int N = 7,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] lvl
);
  always_comb begin
    lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) lvl = W'(i + 1);
    end
  end
  assign any = |req;
endmodule

// File: rtl/iack_timer.sv
// Counts the cycles of one acknowledge cycle and ends it on answer or timeout.
module iack_timer #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            ack,
  input  logic [TO_W-1:0] limit,
  output logic            done,
  output logic            timed_out
);
  logic [TO_W-1:0] cnt;
  logic            at_limit;

  assign at_limit  = (cnt == limit);
  assign done      = active && (ack || at_limit);
  assign timed_out = active && !ack && at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n || !active || done) cnt <= '0;
    else                           cnt <= cnt + TO_W'(1);
  end
endmodule

// File: rtl/report_store.sv
// Fill-then-drain entry buffer: writes append, reads walk from the start, clear empties it.
module report_store #(
  parameter int DEPTH = 16,
  parameter int W     = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_adv,
  input  logic                       clear,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                       full,
  output logic                       rd_avail,
  output logic                       rd_last,
  output logic [W-1:0]               rd_data
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr;
  logic          do_wr;

  assign full     = (cnt == CW'(DEPTH));
  assign do_wr    = wr_en && !full;
  assign rd_avail = (CW'(rd_ptr) < cnt);
  assign rd_last  = (CW'(rd_ptr) + CW'(1) == cnt);
  assign rd_data  = mem[rd_ptr];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_wr && cnt == CW'(g)) mem[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt    <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_wr)  cnt    <= cnt + CW'(1);
      if (rd_adv) rd_ptr <= rd_ptr + PW'(1);
    end
  end
endmodule

// File: rtl/irq_report_seq.sv
module irq_report_seq
  import irq_report_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TO_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   irq_lines,
  input  logic [LINES-1:0]   irq_en,
  output logic               iack_req,
  output logic [LVL_W-1:0]   iack_level,
  input  logic               iack_ack,
  input  logic [ID_W-1:0]    iack_id,
  input  logic [TO_W-1:0]    to_limit,
  input  logic               sig_valid,
  output logic               sig_ready,
  input  logic [ID_W-1:0]    sig_id,
  output logic               rpt_valid,
  input  logic               rpt_ready,
  output logic [ENTRY_W-1:0] rpt_data,
  output logic               rpt_last,
  output logic               rpt_event,
  input  logic               host_ok,
  output logic               ovf_flag
);
  localparam int CW = $clog2(DEPTH + 1);

  seq_state_t       state, state_nx;
  logic [LVL_W-1:0] cur_lvl;
  logic [LINES-1:0] skip;
  logic [LINES-1:0] elig;
  logic             pick_any;
  logic [LVL_W-1:0] pick_lvl;
  logic             t_done, t_to;
  logic [CW-1:0]    buf_cnt;
  logic             buf_full, buf_avail, buf_last;
  logic             wr_en, rd_adv, buf_clear, take_word;
  logic             go_send, ovf_set;
  rpt_entry_t       wr_entry, rd_entry;

  assign elig = irq_lines & irq_en & ~skip;

  irq_level_pick #(.N(LINES), .W(LVL_W)) u_pick (
    .req (elig),
    .any (pick_any),
    .lvl (pick_lvl)
  );

  iack_timer #(.TO_W(TO_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (iack_req),
    .ack       (iack_ack),
    .limit     (to_limit),
    .done      (t_done),
    .timed_out (t_to)
  );

  assign iack_req   = (state == ST_IACK);
  assign iack_level = cur_lvl;

  // Signal words only while no eligible line waits and room remains.
  assign sig_ready = (state == ST_GATHER) && !pick_any && !buf_full;
  assign take_word = sig_valid && sig_ready;

  always_comb begin
    wr_entry = '0;
    if (iack_req) begin
      wr_entry.src  = cur_lvl;
      wr_entry.berr = t_to;
      wr_entry.id   = t_to ? '0 : iack_id;
    end else begin
      wr_entry.id   = sig_id;
    end
  end

  assign wr_en = (iack_req && t_done) || take_word;

  report_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_entry),
    .rd_adv   (rd_adv),
    .clear    (buf_clear),
    .cnt      (buf_cnt),
    .full     (buf_full),
    .rd_avail (buf_avail),
    .rd_last  (buf_last),
    .rd_data  (rd_entry)
  );

  assign rpt_valid = (state == ST_SEND) && buf_avail;
  assign rpt_data  = rd_entry;
  assign rpt_last  = buf_last;
  assign rd_adv    = rpt_valid && rpt_ready && !buf_last;
  assign buf_clear = rpt_valid && rpt_ready && buf_last;

  assign ovf_set = (state == ST_GATHER) && buf_full && (pick_any || sig_valid);
  assign go_send = (state == ST_GATHER) &&
                   (ovf_set || (!pick_any && !sig_valid && buf_cnt != '0));

  always_comb begin
    state_nx = state;
    case (state)
      ST_GATHER: begin
        if (go_send)                   state_nx = ST_SEND;
        else if (pick_any && !buf_full) state_nx = ST_IACK;
      end
      ST_IACK:   if (t_done)    state_nx = ST_GATHER;
      ST_SEND:   if (buf_clear) state_nx = ST_HOLD;
      ST_HOLD:   if (host_ok)   state_nx = ST_GATHER;
      default:                  state_nx = ST_GATHER;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_GATHER;
      cur_lvl   <= '0;
      skip      <= '0;
      ovf_flag  <= 1'b0;
      rpt_event <= 1'b0;
    end else begin
      state     <= state_nx;
      rpt_event <= go_send;
      if (state == ST_GATHER && pick_any && !buf_full) cur_lvl <= pick_lvl;
      if (ovf_set) ovf_flag <= 1'b1;
      else if (state == ST_HOLD && host_ok) ovf_flag <= 1'b0;
      if (buf_clear) skip <= '0;
      else begin
        for (int i = 0; i < LINES; i++) begin
          if (t_to && cur_lvl == LVL_W'(i + 1)) skip[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_report_seq_chk.sv
module irq_report_seq_chk
  import irq_report_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [LINES-1:0]   irq_lines,
  input logic [LINES-1:0]   irq_en,
  input logic               iack_req,
  input logic [LVL_W-1:0]   iack_level,
  input logic               iack_ack,
  input logic               sig_ready,
  input logic               rpt_valid,
  input logic               rpt_ready,
  input logic [ENTRY_W-1:0] rpt_data,
  input logic               rpt_last,
  input logic               rpt_event,
  input logic               host_ok,
  input logic               ovf_flag
);
  // R2
  start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iack_req) |-> $past(|(irq_lines & irq_en)));
  // R3
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req |-> (iack_level != '0 && iack_level <= LVL_W'(LINES)));
  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req && !iack_ack |=> !iack_req || $stable(iack_level));
  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req && iack_ack |=> !iack_req);
  // R6
  one_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(iack_req && (sig_ready || rpt_valid)));
  // R7
  rpt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid && !rpt_ready |=> rpt_valid && $stable(rpt_data) && $stable(rpt_last));
  // R7
  event_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_event |-> rpt_valid);
  // R7
  event_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_event |=> !rpt_event);
  // R8
  gate_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid && rpt_ready && rpt_last |=> !rpt_valid && !iack_req && !sig_ready);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !host_ok |=> ovf_flag);
endmodule

bind irq_report_seq irq_report_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_lines  (irq_lines),
  .irq_en     (irq_en),
  .iack_req   (iack_req),
  .iack_level (iack_level),
  .iack_ack   (iack_ack),
  .sig_ready  (sig_ready),
  .rpt_valid  (rpt_valid),
  .rpt_ready  (rpt_ready),
  .rpt_data   (rpt_data),
  .rpt_last   (rpt_last),
  .rpt_event  (rpt_event),
  .host_ok    (host_ok),
  .ovf_flag   (ovf_flag)
);

// File: tb/test_irq_report_seq.sv
module test_irq_report_seq;
  import irq_report_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [6:0]  pend = '0, irq_en = '0, dead = '0;
  logic        iack_req, iack_ack = 1'b0;
  logic [2:0]  iack_level;
  logic [15:0] iack_id = '0;
  logic [7:0]  to_limit = 8'd5;
  logic        sig_valid, sig_ready;
  logic [15:0] sig_id;
  logic        rpt_valid, rpt_ready = 1'b1, rpt_last, rpt_event, host_ok = 1'b0, ovf_flag;
  logic [19:0] rpt_data;

  logic [15:0] fmem [64];
  logic [5:0]  fhead = '0, ftail = '0;
  assign sig_valid = (fhead != ftail);
  assign sig_id    = fmem[fhead];
  always @(posedge clk) if (sig_valid && sig_ready) fhead <= fhead + 6'd1;

  irq_report_seq i_irq_report_seq (
    .clk(clk), .rst_n(rst_n), .irq_lines(pend), .irq_en(irq_en),
    .iack_req(iack_req), .iack_level(iack_level), .iack_ack(iack_ack),
    .iack_id(iack_id), .to_limit(to_limit), .sig_valid(sig_valid),
    .sig_ready(sig_ready), .sig_id(sig_id), .rpt_valid(rpt_valid),
    .rpt_ready(rpt_ready), .rpt_data(rpt_data), .rpt_last(rpt_last),
    .rpt_event(rpt_event), .host_ok(host_ok), .ovf_flag(ovf_flag));

  int checks = 0, errors = 0;
  int cyc = 0, rcnt = 0, dead_run = 0, evt_n = 0, req_seen = 0, got_n = 0;
  int dly [7];
  bit bp = 1'b0, got_done = 1'b0;
  logic [7:0]  cur_iter = '0;
  logic [19:0] got [32];
  logic [19:0] exp_e [32];
  int exp_n = 0;
  bit exp_ovf = 1'b0;

  function automatic logic [15:0] line_id(input logic [2:0] l);
    return {4'hA, 1'b0, l, cur_iter};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Responder, report sink and event counters, all at the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (iack_ack) begin
      iack_ack = 1'b0;
      rcnt = 0;
    end else if (iack_req && iack_level >= 3'd1 && iack_level <= 3'd7) begin
      if (dead[iack_level-1]) dead_run++;
      else if (rcnt >= dly[iack_level-1]) begin
        iack_ack = 1'b1;
        iack_id  = line_id(iack_level);
        pend[iack_level-1] = 1'b0;
      end else rcnt++;
    end
    rpt_ready = bp ? (cyc % 3 != 0) : 1'b1;
    if (rpt_valid && rpt_ready) begin
      if (got_n < 32) got[got_n] = rpt_data;
      got_n++;
      if (rpt_last) got_done = 1'b1;
    end
    if (rpt_event) evt_n++;
    if (iack_req) req_seen++;
  end

  task automatic push_words(input int n, input int tag);
    for (int k = 0; k < n; k++) begin
      fmem[ftail] = {4'h5, 4'(k), 8'(tag)};
      ftail = ftail + 6'd1;
    end
  endtask

  task automatic clear_obs();
    got_n = 0; got_done = 1'b0; evt_n = 0; dead_run = 0; req_seen = 0;
  endtask

  // Expected report: eligible lines high to low, then signal words, capped at 16.
  task automatic build_exp(input logic [6:0] p, input logic [6:0] e, input logic [6:0] dm,
                           input logic [5:0] wstart, input int nw);
    exp_n = 0;
    for (int l = 7; l >= 1; l--) begin
      if (p[l-1] && e[l-1]) begin
        exp_e[exp_n] = dm[l-1] ? {3'(l), 1'b1, 16'h0} : {3'(l), 1'b0, line_id(3'(l))};
        exp_n++;
      end
    end
    for (int k = 0; k < nw; k++) begin
      exp_e[exp_n] = {3'd0, 1'b0, fmem[wstart + 6'(k)]};
      exp_n++;
    end
    exp_ovf = (exp_n > 16);
    if (exp_ovf) exp_n = 16;
  endtask

  task automatic wait_report();
    for (int w = 0; w < 800 && !got_done; w++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_report(input string tag);
    chk(got_n == exp_n, {tag, " R7 word count"}, got_n, exp_n);
    for (int k = 0; k < exp_n && k < 32; k++)
      chk(got[k] == exp_e[k], {tag, " R3 R11 report word"}, int'(got[k]), int'(exp_e[k]));
    chk(evt_n == 1, {tag, " R7 one event"}, evt_n, 1);
    chk(ovf_flag == exp_ovf, {tag, " R10 overflow flag"}, ovf_flag, exp_ovf);
    chk(!rpt_valid && !iack_req, {tag, " R8 gate closed"}, rpt_valid, 0);
  endtask

  task automatic burst(input logic [6:0] p, input logic [6:0] e, input int nf,
                       input logic [6:0] dm, input bit bpi, input int it);
    logic [5:0] ws;
    @(negedge clk);
    clear_obs();
    cur_iter = 8'(it); dead = dm; bp = bpi;
    for (int l = 0; l < 7; l++) dly[l] = (l + it) % 4;
    ws = ftail;
    push_words(nf, it);
    build_exp(p, e, dm, ws, nf);
    irq_en = e; pend = p; host_ok = 1'b1;
    @(negedge clk);
    host_ok = 1'b0;
    if (exp_n == 0) begin
      repeat (30) @(negedge clk);
      chk(evt_n == 0 && req_seen == 0, "R2 disabled lines ignored", evt_n + req_seen, 0);
      chk(pend == p, "R2 disabled lines left pending", pend, p);
    end else begin
      wait_report();
      check_report("sweep");
      chk((pend & ~e) == (p & ~e), "R2 disabled lines not acknowledged", pend & ~e, p & ~e);
      if (dm != '0)
        chk(dead_run == int'(to_limit) + 1, "R5 timeout window", dead_run, int'(to_limit) + 1);
    end
    pend = '0;
  endtask

  initial begin
    for (int l = 0; l < 7; l++) dly[l] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!iack_req && !rpt_valid && !rpt_event && !ovf_flag, "R1 reset outputs low",
        {iack_req, rpt_valid, rpt_event, ovf_flag}, 0);
    chk(sig_ready, "R1 gate open after reset", sig_ready, 1);

    // R3 R5 R6: sweep of every pending pattern with a varied enable mask.
    for (int i = 0; i < 128; i++) begin
      logic [6:0] p, e, el, dm;
      p  = 7'(i);
      e  = 7'(i * 37 + 11);
      el = p & e;
      dm = '0;
      if (i % 5 == 0 && el != '0) dm = el & (~el + 7'd1);
      burst(p, e, i % 3, dm, i[0], i);
    end

    // R8 R9: requests during the closed gate wait for host_ok.
    @(negedge clk);
    clear_obs();
    cur_iter = 8'hC3; dead = '0; bp = 1'b0;
    irq_en = 7'h7F; pend = 7'b0000100;
    begin
      logic [5:0] ws, h0;
      ws = ftail;
      push_words(1, 200);
      build_exp(7'b0000100, 7'h7F, 7'h00, ws, 1);
      h0 = fhead;
      repeat (40) @(negedge clk);
      chk(req_seen == 0 && evt_n == 0 && !rpt_valid, "R8 no activity while gated",
          req_seen + evt_n, 0);
      chk(fhead == h0, "R8 no signal word taken while gated", fhead, h0);
    end
    host_ok = 1'b1; @(negedge clk); host_ok = 1'b0;
    wait_report();
    check_report("R9 after re-arm");

    // R10: overflow with lines 7, 5, 2 and 20 signal words.
    @(negedge clk);
    clear_obs();
    cur_iter = 8'hD1; bp = 1'b1;
    begin
      logic [5:0] ws;
      ws = ftail;
      push_words(20, 210);
      build_exp(7'b1010010, 7'h7F, 7'h00, ws, 20);
      pend = 7'b1010010;
      host_ok = 1'b1; @(negedge clk); host_ok = 1'b0;
      wait_report();
      check_report("R10 overflow");
      chk(int'(ftail - fhead) == 7, "R10 remaining words left queued", int'(ftail - fhead), 7);
      repeat (10) @(negedge clk);
      chk(ovf_flag, "R10 flag sticky while gated", ovf_flag, 1);
      clear_obs();
      ws = fhead;
      build_exp(7'h00, 7'h7F, 7'h00, ws, 7);
      host_ok = 1'b1; @(negedge clk); host_ok = 1'b0;
      chk(!ovf_flag, "R10 flag cleared by re-arm", ovf_flag, 0);
      wait_report();
      check_report("R10 leftover words");
    end

    // R10 boundary: exactly sixteen words fill the buffer without overflow.
    @(negedge clk);
    clear_obs();
    begin
      logic [5:0] ws;
      ws = ftail;
      push_words(16, 220);
      build_exp(7'h00, 7'h7F, 7'h00, ws, 16);
      host_ok = 1'b1; @(negedge clk); host_ok = 1'b0;
      wait_report();
      check_report("R10 exact fill");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule